// File: doc/BRIEF.md
# Seeded BCD Watchdog Down-Counter

This block is a watchdog timer whose count is held as four packed BCD digits, giving a timeout from 00.01 to 99.99 seconds in 10 ms steps. A 100 Hz strobe (`tick_i`) paces the count. A host reaches the block through a small byte-wide register port. That port holds two count bytes, a control byte and a status byte. A seed register remembers the last value the host wrote. Any host access to the count bytes while the watchdog is enabled restarts the count from that seed. Software therefore keeps the timer alive simply by touching its count registers.

When the count steps down to zero, a sticky expiry flag is set. If the reset-enable bit is set, a reset request is also issued; a separate block is expected to stretch that request into a reset pulse. A written count of zero is never decremented, so it leaves the watchdog idle. With the enable bit clear, the two count bytes act as plain read/write storage.

Register map (byte addresses):
- 0: count low byte. Upper nibble is tenths of a second, lower nibble is hundredths.
- 1: count high byte. Upper nibble is tens of seconds, lower nibble is seconds.
- 2: control. Bit 0 is the enable bit and bit 1 is the reset-enable bit.
- 3: status. Bit 0 is the expiry flag.

Top module: `bcd_wdog`

## Requirements
- R1: After reset the counter, seed, control bits, expiry flag and `rst_req_o` are all zero, and every register address reads 0x00.
- R2: A host write to a count byte loads that byte into both the live counter and the seed. While enabled, the other count byte of the live counter is reloaded from the seed in the same cycle.
- R3: A read is issued with `reg_rd_i` high for one cycle, and `reg_rdata_o` holds the result from the next cycle on. A read of address 0 returns the count low byte as it was before the access and captures the whole count. A read of address 1 returns the high byte captured by the last address-0 read. While enabled, either count read reloads the counter from the seed.
- R4: With the enable bit at 1, each `tick_i` cycle with a non-zero count lowers it by one hundredth, borrowing across BCD digits (10.00 becomes 09.99, 01.00 becomes 00.99, 00.10 becomes 00.09).
- R5: The decrement that reaches 00.00 sets status bit 0. If reset-enable is 1, `rst_req_o` is high for exactly the one cycle after that edge.
- R6: An expiry with reset-enable at 0 sets the flag but never raises `rst_req_o`.
- R7: A count written as 00.00 while enabled is left unchanged by ticks and sets neither the flag nor `rst_req_o`.
- R8: The expiry flag stays set until the host writes status bit 0 as 0. Writing it as 1 has no effect.
- R9: After expiry the counter holds at 00.00, and further ticks raise neither the flag nor `rst_req_o` until the counter is reloaded.
- R10: With the enable bit at 0, ticks do not change the count bytes. They read back exactly as written, and reading them does not change them.
- R11: A host count write in the same cycle as `tick_i` takes priority. The tick is dropped and the written value stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 100 Hz count strobe |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_rd_i | input | 1 | Host register read strobe |
| reg_addr_i | input | 2 | Register byte address |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Registered read data |
| rst_req_o | output | 1 | Reset request on expiry |

## Verification
Counting is tried from several start values. Those from 10.00, 01.00 and 00.10 tell a correct multi-digit borrow apart from a nibble-local or binary decrement. A short run from 00.02 separates a true expiry from a plain decrement. Written zero, expiry with and without reset-enable, and ticks after expiry distinguish a zero that was reached by counting from one that was loaded. Disabled-mode storage checks and a write issued in the same cycle as a tick separate the reload and priority rules from the counting path.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int BCD_W       = 4;
   localparam int BYTE_W      = 8;
   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_RE_BIT  = 1;
   localparam int STS_EXP_BIT = 0;

   typedef enum logic [1:0] {
      RK_COUNT  = 2'd0,
      RK_CTRL   = 2'd1,
      RK_STATUS = 2'd2,
      RK_NONE   = 2'd3
   } reg_kind_t;
endpackage

// File: rtl/wdog_bcd_digit.sv
module wdog_bcd_digit
   import wdog_pkg::*;
(
   input  logic [BCD_W-1:0] digit_i,
   input  logic             borrow_i,
   output logic [BCD_W-1:0] digit_o,
   output logic             borrow_o
);
   always_comb begin
      if (!borrow_i) begin
         digit_o  = digit_i;
         borrow_o = 1'b0;
      end else if (digit_i == '0) begin
         digit_o  = BCD_W'(9);
         borrow_o = 1'b1;
      end else begin
         digit_o  = digit_i - BCD_W'(1);
         borrow_o = 1'b0;
      end
   end

   always_comb begin
      if (digit_i <= BCD_W'(9))
         AST_DIGIT_IN_RANGE: assert (digit_o <= BCD_W'(9)); // R4
   end
endmodule

// File: rtl/wdog_bcd_dec.sv
module wdog_bcd_dec
   import wdog_pkg::*;
#(
   parameter int NDIG = 4,
   localparam int VW  = NDIG * BCD_W
)(
   input  logic [VW-1:0] value_i,
   output logic [VW-1:0] value_o,
   output logic          was_zero_o
);
   logic [NDIG:0] borrow;
   assign borrow[0] = 1'b1;

   generate
      for (genvar g = 0; g < NDIG; g++) begin : g_digit
         wdog_bcd_digit u_digit (
            .digit_i  (value_i[g*BCD_W +: BCD_W]),
            .borrow_i (borrow[g]),
            .digit_o  (value_o[g*BCD_W +: BCD_W]),
            .borrow_o (borrow[g+1])
         );
      end
   endgenerate

   // a borrow out of the top digit means every digit was zero
   assign was_zero_o = borrow[NDIG];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int NDIG   = 4,
   localparam int VW     = NDIG * BCD_W,
   localparam int NBYTES = NDIG / 2,
   localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              enable_i,
   input  logic              cnt_wr_i,
   input  logic              cnt_rd_i,
   input  logic [IW-1:0]     byte_idx_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [VW-1:0]     count_o,
   output logic              hit_o
);
   logic [VW-1:0] count_q, seed_q, dec_val;
   logic          is_zero, dec_go, access;

   wdog_bcd_dec #(.NDIG(NDIG)) u_dec (
      .value_i    (count_q),
      .value_o    (dec_val),
      .was_zero_o (is_zero)
   );

   assign access = cnt_wr_i || cnt_rd_i;
   assign dec_go = tick_i && enable_i && !is_zero && !access;
   assign hit_o  = dec_go && (dec_val == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         seed_q  <= '0;
      end else if (cnt_wr_i) begin
         for (int b = 0; b < NBYTES; b++) begin
            if (byte_idx_i == IW'(b)) begin
               count_q[b*BYTE_W +: BYTE_W] <= wdata_i;
               seed_q [b*BYTE_W +: BYTE_W] <= wdata_i;
            end else if (enable_i) begin
               count_q[b*BYTE_W +: BYTE_W] <= seed_q[b*BYTE_W +: BYTE_W];
            end
         end
      end else if (cnt_rd_i && enable_i) begin
         count_q <= seed_q;
      end else if (dec_go) begin
         count_q <= dec_val;
      end
   end

   assign count_o = count_q;

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && !access) |=> (count_q == '0)); // R9

   AST_IDLE_IS_STORAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && !cnt_wr_i) |=> $stable(count_q)); // R10

   AST_ACCESS_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_i && tick_i) |=> (count_q[byte_idx_i*BYTE_W +: BYTE_W] == $past(wdata_i))); // R11
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags
   import wdog_pkg::*;
#(
   parameter bit REQ_HOLD = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_wr_i,
   input  logic ctl_en_i,
   input  logic ctl_re_i,
   input  logic sts_wr_i,
   input  logic sts_bit_i,
   input  logic hit_i,
   output logic enable_o,
   output logic rst_en_o,
   output logic flag_o,
   output logic rst_req_o
);
   logic en_q, re_q, flag_q, req_q, clear;

   assign clear = sts_wr_i && !sts_bit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         re_q <= 1'b0;
      end else if (ctl_wr_i) begin
         en_q <= ctl_en_i;
         re_q <= ctl_re_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (hit_i)  flag_q <= 1'b1;
      else if (clear)  flag_q <= 1'b0;
   end

   generate
      if (REQ_HOLD) begin : g_req_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              req_q <= 1'b0;
            else if (hit_i && re_q)  req_q <= 1'b1;
            else if (clear)          req_q <= 1'b0;
         end
      end else begin : g_req_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= hit_i && re_q;
         end
      end
   endgenerate

   assign enable_o  = en_q;
   assign rst_en_o  = re_q;
   assign flag_o    = flag_q;
   assign rst_req_o = req_q;

   AST_REQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !$past(clear)) |-> flag_q); // R5

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clear) |=> flag_q); // R8

   AST_NO_REQ_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!re_q && !REQ_HOLD) |=> !req_q); // R6
endmodule

// File: rtl/bcd_wdog.sv
module bcd_wdog
   import wdog_pkg::*;
#(
   parameter int  NDIG     = 4,
   parameter bit  REQ_HOLD = 1'b0,
   localparam int NBYTES   = NDIG / 2,
   localparam int AW       = $clog2(NBYTES + 2)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [AW-1:0]     reg_addr_i,
   input  logic [BYTE_W-1:0] reg_wdata_i,
   output logic [BYTE_W-1:0] reg_rdata_o,
   output logic              rst_req_o
);
   localparam int VW = NDIG * BCD_W;
   localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [AW-1:0] A_CTRL   = AW'(NBYTES);
   localparam logic [AW-1:0] A_STATUS = AW'(NBYTES + 1);

   generate
      if (NDIG < 2 || (NDIG % 2) != 0) begin : g_bad_ndig
         $error("NDIG must be an even count of at least two digits");
      end
   endgenerate

   reg_kind_t         kind;
   logic [IW-1:0]     idx;
   logic              cnt_wr, cnt_rd, ctl_wr, sts_wr;
   logic              enable, rst_en, flag, hit;
   logic [VW-1:0]     count, snap_q;
   logic [BYTE_W-1:0] rdata_q, rd_mux;

   always_comb begin
      if (reg_addr_i < A_CTRL)        kind = RK_COUNT;
      else if (reg_addr_i == A_CTRL)  kind = RK_CTRL;
      else if (reg_addr_i == A_STATUS) kind = RK_STATUS;
      else                            kind = RK_NONE;
   end

   assign idx    = reg_addr_i[IW-1:0];
   assign cnt_wr = reg_wr_i && (kind == RK_COUNT);
   assign cnt_rd = reg_rd_i && !reg_wr_i && (kind == RK_COUNT);
   assign ctl_wr = reg_wr_i && (kind == RK_CTRL);
   assign sts_wr = reg_wr_i && (kind == RK_STATUS);

   wdog_counter #(.NDIG(NDIG)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .enable_i   (enable),
      .cnt_wr_i   (cnt_wr),
      .cnt_rd_i   (cnt_rd),
      .byte_idx_i (idx),
      .wdata_i    (reg_wdata_i),
      .count_o    (count),
      .hit_o      (hit)
   );

   wdog_flags #(.REQ_HOLD(REQ_HOLD)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr_i  (ctl_wr),
      .ctl_en_i  (reg_wdata_i[CTL_EN_BIT]),
      .ctl_re_i  (reg_wdata_i[CTL_RE_BIT]),
      .sts_wr_i  (sts_wr),
      .sts_bit_i (reg_wdata_i[STS_EXP_BIT]),
      .hit_i     (hit),
      .enable_o  (enable),
      .rst_en_o  (rst_en),
      .flag_o    (flag),
      .rst_req_o (rst_req_o)
   );

   always_comb begin
      rd_mux = '0;
      unique case (kind)
         RK_COUNT: begin
            if (idx == '0) rd_mux = count[BYTE_W-1:0];
            else           rd_mux = snap_q[idx*BYTE_W +: BYTE_W];
         end
         RK_CTRL: begin
            rd_mux[CTL_EN_BIT] = enable;
            rd_mux[CTL_RE_BIT] = rst_en;
         end
         RK_STATUS: rd_mux[STS_EXP_BIT] = flag;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q  <= '0;
         rdata_q <= '0;
      end else if (reg_rd_i) begin
         rdata_q <= rd_mux;
         if (cnt_rd && idx == '0) snap_q <= count;
      end
   end

   assign reg_rdata_o = rdata_q;

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_i |=> $stable(reg_rdata_o)); // R3
endmodule

// File: tb/sim_bcd_wdog.sv
module sim_bcd_wdog;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rst_req;

   int total = 0;
   int bad = 0;
   logic req_seen;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   bcd_wdog u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_req_o(rst_req)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   // driver: queue the expected byte, then issue the read
   task automatic rreg(input logic [1:0] a, input logic [7:0] expv, input string tag);
      @(negedge clk); rd = 1'b1; addr = a;
      exp_q.push_back(expv); tag_q.push_back(tag);
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      req_seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         req_seen = req_seen | rst_req;
      end
   endtask

   // monitor: compare registered read data just after the capturing edge
   always @(posedge clk) begin
      if (rd) begin
         #2;
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R3 actual=%h expected=<none queued>", rdata);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 rst_req", {7'b0, rst_req}, 8'h00);
      rreg(2'd0, 8'h00, "R1 lo");
      rreg(2'd1, 8'h00, "R1 hi");
      rreg(2'd2, 8'h00, "R1 ctrl");
      rreg(2'd3, 8'h00, "R1 status");

      // R10 disabled: plain storage
      wreg(2'd0, 8'h5A); wreg(2'd1, 8'hC3);
      ticks(5);
      rreg(2'd0, 8'h5A, "R10 lo"); rreg(2'd1, 8'hC3, "R10 hi");
      rreg(2'd0, 8'h5A, "R10 lo again"); rreg(2'd1, 8'hC3, "R10 hi again");

      // R4 borrow 10.00 -> 09.99
      wreg(2'd2, 8'h01);
      rreg(2'd2, 8'h01, "R1 ctrl readback");
      wreg(2'd1, 8'h10); wreg(2'd0, 8'h00);
      ticks(1);
      rreg(2'd0, 8'h99, "R4 10.00 lo"); rreg(2'd1, 8'h09, "R4 10.00 hi");
      // R3 read reloads from seed
      rreg(2'd0, 8'h00, "R3 reload lo"); rreg(2'd1, 8'h10, "R3 reload hi");
      ticks(3);
      rreg(2'd0, 8'h97, "R3 latched lo"); rreg(2'd1, 8'h09, "R3 snapshot hi");
      rreg(2'd0, 8'h00, "R3 after reload lo"); rreg(2'd1, 8'h10, "R3 after reload hi");
      // R4 01.00 -> 00.99 and 00.10 -> 00.09
      wreg(2'd1, 8'h01); wreg(2'd0, 8'h00);
      ticks(1);
      rreg(2'd0, 8'h99, "R4 01.00 lo"); rreg(2'd1, 8'h00, "R4 01.00 hi");
      wreg(2'd1, 8'h00); wreg(2'd0, 8'h10);
      ticks(1);
      rreg(2'd0, 8'h09, "R4 00.10 lo"); rreg(2'd1, 8'h00, "R4 00.10 hi");

      // R2 write one byte, other byte reloads from seed (seed = 00.10)
      ticks(2);
      wreg(2'd1, 8'h02);
      rreg(2'd0, 8'h10, "R2 lo from seed"); rreg(2'd1, 8'h02, "R2 hi written");

      // R5 expiry with reset-enable
      wreg(2'd2, 8'h03);
      wreg(2'd1, 8'h00); wreg(2'd0, 8'h02);
      ticks(1);
      check("R5 no early req", {7'b0, req_seen}, 8'h00);
      ticks(1);
      check("R5 req at expiry", {7'b0, rst_req}, 8'h01);
      @(negedge clk);
      check("R5 req one cycle", {7'b0, rst_req}, 8'h00);
      rreg(2'd3, 8'h01, "R5 flag set");
      // R9 held at zero
      ticks(3);
      check("R9 no second req", {7'b0, req_seen}, 8'h00);
      // R8 sticky
      wreg(2'd3, 8'h01);
      rreg(2'd3, 8'h01, "R8 write 1 ignored");
      wreg(2'd3, 8'h00);
      rreg(2'd3, 8'h00, "R8 write 0 clears");
      ticks(2);
      rreg(2'd3, 8'h00, "R9 no new flag");
      check("R9 no req", {7'b0, req_seen}, 8'h00);
      rreg(2'd0, 8'h00, "R9 lo zero"); rreg(2'd1, 8'h00, "R9 hi zero");

      // R6 expiry without reset-enable
      wreg(2'd2, 8'h01);
      wreg(2'd1, 8'h00); wreg(2'd0, 8'h01);
      ticks(1);
      check("R6 no req", {7'b0, req_seen}, 8'h00);
      rreg(2'd3, 8'h01, "R6 flag set");
      wreg(2'd3, 8'h00);

      // R7 written zero stays idle
      wreg(2'd2, 8'h03);
      wreg(2'd1, 8'h00); wreg(2'd0, 8'h00);
      ticks(4);
      check("R7 no req", {7'b0, req_seen}, 8'h00);
      rreg(2'd3, 8'h00, "R7 no flag");
      rreg(2'd0, 8'h00, "R7 lo"); rreg(2'd1, 8'h00, "R7 hi");

      // R11 write wins over tick
      wreg(2'd1, 8'h00);
      @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 8'h50; tick = 1'b1;
      @(negedge clk); wr = 1'b0; tick = 1'b0;
      rreg(2'd0, 8'h50, "R11 lo"); rreg(2'd1, 8'h00, "R11 hi");

      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule